// File: doc/BRIEF.md
# Multiplexer-Based Configurable Logic Cell Array

This block is a row of fine-grained programmable logic cells. Each cell is built around a four-input multiplexer. Its two select lines are not plain inputs. The low select is the AND of one pair of inputs and the high select is the OR of another pair. Because of that gating, one cell can realise a function of up to eight inputs. An optional storage stage follows the multiplexer.

A two-bit configuration word picks one of four modes for the whole row:

- a pass-through stage with no storage;
- a rising-edge flip-flop with asynchronous clear;
- a transparent latch with clear;
- a reduced two-input multiplexer that feeds the latch with clear.

The configuration word is loaded while reset is held and is then frozen. Each cell has its own clear, gate and data inputs, and the cells work independently of one another.

Top module: `lcell_array`

## Requirements
- R1: For every cell, the low select is `a0 & b0` and the high select is `a1 | b1`. The full result is `d00`, `d01`, `d10` or `d11` for the select pair {high,low} = 00, 01, 10 or 11 respectively.
- R2: In mode 2'b00 (pass-through), `y` equals the full result in the same cycle, with no clock delay. In this mode `clr` and `gate` have no effect.
- R3: In mode 2'b01 (flip-flop), `y` takes the full result present at each rising `clk` edge and holds it until the next edge. In this mode `gate` has no effect.
- R4: In mode 2'b10 (latch), `y` follows the full result while `gate` is 1 and holds its value while `gate` is 0.
- R5: In mode 2'b11 (reduced latch), the latch input is a 2:1 choice: `d01` when `a0 & b0` is 1 and `d00` otherwise. It uses the same gate behaviour as R4.
- R6: In modes 01, 10 and 11, a 1 on a cell's `clr` forces that cell's `y` to 0 at once. This does not wait for a clock edge, and it overrides both `gate` and `clk`.
- R7: The mode is taken from `mode_cfg` only on clock edges where `rst` is 1. Changes of `mode_cfg` after reset is released do not change the behaviour.
- R8: In modes 01, 10 and 11, `y` is 0 while `rst` is held: from the first clock edge of reset in flip-flop mode, and at once in the latch modes.

Every `NUM_CELLS`-bit port below carries one bit per cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flip-flop stage and the mode register |
| rst | input | 1 | Synchronous active-high reset; loads the mode and clears storage |
| mode_cfg | input | 2 | Mode word: 00 pass-through, 01 flip-flop, 10 latch, 11 reduced latch |
| clr | input | NUM_CELLS | Per-cell active-high asynchronous clear |
| gate | input | NUM_CELLS | Per-cell latch enable, active high |
| a0 | input | NUM_CELLS | First input of the AND select pair |
| b0 | input | NUM_CELLS | Second input of the AND select pair |
| a1 | input | NUM_CELLS | First input of the OR select pair |
| b1 | input | NUM_CELLS | Second input of the OR select pair |
| d00 | input | NUM_CELLS | Multiplexer data for selects 00 |
| d01 | input | NUM_CELLS | Multiplexer data for selects 01 |
| d10 | input | NUM_CELLS | Multiplexer data for selects 10 |
| d11 | input | NUM_CELLS | Multiplexer data for selects 11 |
| y | output | NUM_CELLS | Per-cell output |

## Verification
Inputs change on the falling edge of the clock. Each check is taken 8 ns later, 2 ns before the next rising edge.

Pass-through and latch results, and the effect of a clear, are due with zero cycles of delay. The bench therefore compares them with a model that it updates the moment it drives the inputs. A flip-flop result is due one rising edge after its inputs. The model copies the full result into its flop state only after that edge and compares it in the following cycle.

The reset value is checked after the first rising edge inside reset. That is the earliest point at which the flip-flop value is defined.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  typedef enum logic [1:0] {
    CM_BYPASS = 2'b00,
    CM_FLOP   = 2'b01,
    CM_LATCH  = 2'b10,
    CM_RLATCH = 2'b11
  } cell_mode_e;

endpackage

// File: rtl/lcell_core.sv
module lcell_core (
  input  logic a0,
  input  logic b0,
  input  logic a1,
  input  logic b1,
  input  logic d00,
  input  logic d01,
  input  logic d10,
  input  logic d11,
  output logic f_full,
  output logic f_red
);

  logic sel_lo;
  logic sel_hi;

  // Gated selects: an AND pair and an OR pair
  assign sel_lo = a0 & b0;
  assign sel_hi = a1 | b1;

  always_comb begin
    unique case ({sel_hi, sel_lo})
      2'b00:   f_full = d00;
      2'b01:   f_full = d01;
      2'b10:   f_full = d10;
      default: f_full = d11;
    endcase
  end

  // Reduced variant: single select, two data inputs
  assign f_red = sel_lo ? d01 : d00;

  // R1: the full result must be one of the data inputs
  always_comb begin
    if (!$isunknown({a0, b0, a1, b1, d00, d01, d10, d11}))
      a_full_is_data_r1: assert (f_full == d00 || f_full == d01 ||
                                 f_full == d10 || f_full == d11);
  end

endmodule

// File: rtl/lcell_store.sv
module lcell_store (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic gate,
  input  logic d_ff,
  input  logic d_lat,
  output logic q_ff,
  output logic q_lat
);

  always_ff @(posedge clk or posedge clr) begin
    if (clr)      q_ff <= 1'b0;
    else if (rst) q_ff <= 1'b0;
    else          q_ff <= d_ff;
  end

  always_latch begin
    if (clr || rst) q_lat = 1'b0;
    else if (gate)  q_lat = d_lat;
  end

  p_ff_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr && !$past(clr) && !$past(rst)) |-> (q_ff == $past(d_ff)));

  p_ff_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clr |-> (q_ff == 1'b0));

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!gate && !$past(gate) && !clr && !$past(clr) && !$past(rst)) |-> $stable(q_lat));

endmodule

// File: rtl/lcell_array.sv
module lcell_array
  import lcell_pkg::*;
#(
  parameter int NUM_CELLS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode_cfg,
  input  logic [NUM_CELLS-1:0] clr,
  input  logic [NUM_CELLS-1:0] gate,
  input  logic [NUM_CELLS-1:0] a0,
  input  logic [NUM_CELLS-1:0] b0,
  input  logic [NUM_CELLS-1:0] a1,
  input  logic [NUM_CELLS-1:0] b1,
  input  logic [NUM_CELLS-1:0] d00,
  input  logic [NUM_CELLS-1:0] d01,
  input  logic [NUM_CELLS-1:0] d10,
  input  logic [NUM_CELLS-1:0] d11,
  output logic [NUM_CELLS-1:0] y
);

  cell_mode_e mode_q;

  // Mode is loaded only while reset is held, then frozen
  always_ff @(posedge clk) begin
    if (rst) mode_q <= cell_mode_e'(mode_cfg);
  end

  p_mode_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    logic f_full;
    logic f_red;
    logic lat_d;
    logic q_ff;
    logic q_lat;

    lcell_core u_core (
      .a0    (a0[i]),
      .b0    (b0[i]),
      .a1    (a1[i]),
      .b1    (b1[i]),
      .d00   (d00[i]),
      .d01   (d01[i]),
      .d10   (d10[i]),
      .d11   (d11[i]),
      .f_full(f_full),
      .f_red (f_red)
    );

    assign lat_d = (mode_q == CM_RLATCH) ? f_red : f_full;

    lcell_store u_store (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr[i]),
      .gate (gate[i]),
      .d_ff (f_full),
      .d_lat(lat_d),
      .q_ff (q_ff),
      .q_lat(q_lat)
    );

    always_comb begin
      unique case (mode_q)
        CM_BYPASS: y[i] = f_full;
        CM_FLOP:   y[i] = q_ff;
        default:   y[i] = q_lat;
      endcase
    end

    p_store_clear_r6: assert property (@(posedge clk) disable iff (rst)
      (mode_q != CM_BYPASS && clr[i]) |-> (y[i] == 1'b0));

    p_storage_reset_r8: assert property (@(posedge clk)
      ($past(rst) && rst && mode_q != CM_BYPASS) |-> (y[i] == 1'b0));
  end

endmodule

// File: tb/sim_lcell_array.sv
module sim_lcell_array;

  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode_cfg = 2'b00;
  logic [NC-1:0] clr = '0, gate = '0;
  logic [NC-1:0] a0 = '0, b0 = '0, a1 = '0, b1 = '0;
  logic [NC-1:0] d00 = '0, d01 = '0, d10 = '0, d11 = '0;
  logic [NC-1:0] y;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [NC-1:0] ff_e, lat_e;
  int cur_mode;

  lcell_array #(.NUM_CELLS(NC)) u0 (
    .clk(clk), .rst(rst), .mode_cfg(mode_cfg), .clr(clr), .gate(gate),
    .a0(a0), .b0(b0), .a1(a1), .b1(b1),
    .d00(d00), .d01(d01), .d10(d10), .d11(d11), .y(y)
  );

  always #10 clk = ~clk;

  function automatic logic full_f(int i);
    logic s0, s1;
    s0 = a0[i] & b0[i];
    s1 = a1[i] | b1[i];
    case ({s1, s0})
      2'b00:   return d00[i];
      2'b01:   return d01[i];
      2'b10:   return d10[i];
      default: return d11[i];
    endcase
  endfunction

  function automatic logic red_f(int i);
    return (a0[i] & b0[i]) ? d01[i] : d00[i];
  endfunction

  task automatic drive_data();
    a0 = NC'($urandom); b0 = NC'($urandom); a1 = NC'($urandom); b1 = NC'($urandom);
    d00 = NC'($urandom); d01 = NC'($urandom); d10 = NC'($urandom); d11 = NC'($urandom);
  endtask

  task automatic settle_check(string tag);
    for (int i = 0; i < NC; i++) begin
      if (clr[i] || rst) lat_e[i] = 1'b0;
      else if (gate[i]) lat_e[i] = (cur_mode == 3) ? red_f(i) : full_f(i);
      if (clr[i]) ff_e[i] = 1'b0;
    end
    #8;
    for (int i = 0; i < NC; i++) begin
      logic e;
      case (cur_mode)
        0:       e = full_f(i);
        1:       e = ff_e[i];
        default: e = lat_e[i];
      endcase
      total++;
      if (y[i] !== e) begin
        bad++;
        $display("FAIL %s mode=%0d lane=%0d y=%b exp=%b", tag, cur_mode, i, y[i], e);
      end
    end
  endtask

  task automatic post_edge();
    @(posedge clk);
    for (int i = 0; i < NC; i++)
      ff_e[i] = (rst || clr[i]) ? 1'b0 : full_f(i);
  endtask

  task automatic do_reset(int m);
    @(negedge clk);
    rst = 1'b1; mode_cfg = 2'(m); clr = '0; gate = '0; cur_mode = m;
    drive_data();
    lat_e = '0;
    post_edge();
    @(negedge clk);
    drive_data(); gate = NC'($urandom);
    settle_check("R8");
    post_edge();
    @(negedge clk);
    rst = 1'b0; mode_cfg = ~2'(m); gate = '0;
    settle_check("R8");
    post_edge();
  endtask

  task automatic rand_cycles(int n, string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      drive_data();
      gate = NC'($urandom);
      for (int i = 0; i < NC; i++) clr[i] = (($urandom % 8) == 0);
      mode_cfg = 2'($urandom);
      settle_check(tag);
      post_edge();
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    ff_e = '0; lat_e = '0; cur_mode = 0;

    // Pass-through: every select combination, clear and gate toggling
    do_reset(0);
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      drive_data();
      a0 = {NC{s[0]}}; b0 = {NC{s[1]}}; a1 = {NC{s[2]}}; b1 = {NC{s[3]}};
      clr = NC'($urandom); gate = NC'($urandom);
      settle_check("R1 R2");
      post_edge();
    end
    rand_cycles(40, "R1 R2 R7");

    // Flip-flop mode
    do_reset(1);
    rand_cycles(60, "R3 R7");

    // Latch mode, including clear against an open gate
    do_reset(2);
    rand_cycles(60, "R4 R7");
    @(negedge clk);
    drive_data(); gate = '1; clr = '1;
    settle_check("R6");
    post_edge();
    @(negedge clk);
    clr = '0; gate = '0; drive_data();
    settle_check("R4 R6");
    post_edge();

    // Reduced latch mode
    do_reset(3);
    rand_cycles(60, "R5 R7");

    // Flip-flop clear between edges
    do_reset(1);
    @(negedge clk);
    drive_data(); d00 = '1; d01 = '1; d10 = '1; d11 = '1; clr = '0;
    settle_check("R3");
    post_edge();
    @(negedge clk);
    clr = '1;
    settle_check("R6");
    post_edge();
    @(negedge clk);
    clr = '0;
    settle_check("R6");
    post_edge();

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule